// File: doc/BRIEF.md
# Sort-then-route 8x8 cell switch fabric

This block switches up to eight fixed-size cells per clock from eight input lanes to eight output ports. Each input lane offers a valid bit, a 3-bit destination tag and a payload word. The cells first pass through a bitonic compare-exchange sorting network. Its compare elements alternate their direction so that ordered halves merge into larger ordered runs. The network puts the cells in ascending tag order, with idle lanes treated as keys above every real tag. The sorted, packed set then enters a three-stage self-routing shuffle-exchange network. At each stage it steers on one tag bit, most significant bit first. Because the input to that network is sorted and packed, no two cells ever ask for the same switch output.

Every stage is registered: six sort stages and three routing stages. A new set of cells can enter every clock. A control section tracks which pipeline stages hold live cells and enables only those stage registers. It also flags any batch in which two valid cells carry the same tag, and raises that flag in the same cycle the batch reaches the outputs.

Top module: `sort_route_fabric`

## Requirements
- R1: A valid input cell whose 3-bit tag is t, in a batch with no repeated tag, leaves on output port t with its payload unchanged. Port t is bit t of `outValid` and bits [8t+7:8t] of `outData`. The tag of input lane i is bits [3i+2:3i] of `inTags`, and its payload is bits [8i+7:8i] of `inData`.
- R2: The latency is exactly 9 clock edges. A batch sampled at edge n appears on the outputs after edge n+8 and is held only until edge n+9.
- R3: A full batch holding all eight tags in any order delivers all eight cells, with none lost.
- R4: An output port whose tag matches no valid cell of the batch shows `outValid` low for that batch.
- R5: A partial batch, with idle lanes in any positions and any unique tags on the valid lanes, delivers every valid cell. The sort key is {not valid, tag}, so idle lanes go to the end of the sorted order.
- R6: `dupErr` is high in exactly the cycle a batch containing two valid cells with the same tag reaches the outputs, and low for every other batch. In a flagged batch the port contents are not defined.
- R7: Batches offered on consecutive clocks do not affect one another. Only stage registers that hold, or are about to receive, valid cells are enabled.
- R8: After reset, `outValid` is all zero and `dupErr` is low until cells from a new batch arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 8 | Valid bit per input lane |
| inTags | input | 24 | 3-bit destination tag per lane, lane i in bits [3i+2:3i] |
| inData | input | 8*DATA_W | Payload per lane, lane i in bits [DATA_W*i+DATA_W-1:DATA_W*i] |
| outValid | output | 8 | Cell present per output port |
| outData | output | 8*DATA_W | Payload per output port |
| dupErr | output | 1 | Batch at the outputs had a repeated tag |

## Verification
A compare element with the wrong direction, or a wrongly wired shuffle, leaves the routing network with an unsorted set. The result at the ports is a missing or misplaced cell exactly nine cycles after the offending batch. The bench therefore checks each port on every cycle against a queue-based model of batches. A stage enable that is dropped too early freezes stale cells in a register, and these reappear as ghost valid bits on later idle cycles. A misaligned flag pipeline shows up as `dupErr` one cycle off from its batch.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int LOGN         = 3;
  localparam int NPORT        = 1 << LOGN;
  localparam int SORT_STAGES  = LOGN * (LOGN + 1) / 2;
  localparam int ROUTE_STAGES = LOGN;
  localparam int STAGES       = SORT_STAGES + ROUTE_STAGES;

  typedef logic [LOGN-1:0] tag_t;

  typedef struct packed {
    logic [STAGES-1:0] stageEn;
  } strobes_t;
endpackage

// File: rtl/srf_control.sv
module srf_control import srf_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] inValid,
  input  tag_t             inTag [NPORT],
  output strobes_t         stb,
  output logic             dupErr
);
  logic [STAGES-1:0] occ;
  logic [STAGES-1:0] dupPipe;
  logic              anyIn;
  logic              dupNow;

  always_comb begin
    anyIn  = |inValid;
    dupNow = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      for (int j = i + 1; j < NPORT; j++) begin
        if (inValid[i] && inValid[j] && (inTag[i] == inTag[j])) dupNow = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ     <= '0;
      dupPipe <= '0;
    end else begin
      occ     <= {occ[STAGES-2:0], anyIn};
      dupPipe <= {dupPipe[STAGES-2:0], dupNow};
    end
  end

  // a stage loads when its feeder holds cells or it must empty itself
  always_comb stb.stageEn = occ | {occ[STAGES-2:0], anyIn};

  assign dupErr = dupPipe[STAGES-1];

  // R8: flag low in the first cycle after reset
  a_r8_flag_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dupErr);

  // R6: a flagged batch always carries cells at the last stage
  a_r6_flag_has_cells: assert property (@(posedge clk) disable iff (rst)
    dupErr |-> occ[STAGES-1]);
endmodule

// File: rtl/srf_datapath.sv
module srf_datapath import srf_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          stb,
  input  logic [NPORT-1:0]  inValid,
  input  tag_t              inTag  [NPORT],
  input  logic [DATA_W-1:0] inData [NPORT],
  output logic [NPORT-1:0]  outValid,
  output logic [DATA_W-1:0] outData [NPORT]
);
  logic [NPORT-1:0]  curV [STAGES+1];
  tag_t              curT [STAGES+1][NPORT];
  logic [DATA_W-1:0] curD [STAGES+1][NPORT];
  logic [NPORT-1:0]  nxV  [STAGES];
  tag_t              nxT  [STAGES][NPORT];
  logic [DATA_W-1:0] nxD  [STAGES][NPORT];
  logic [NPORT-1:0]  regV [STAGES];
  tag_t              regT [STAGES][NPORT];
  logic [DATA_W-1:0] regD [STAGES][NPORT];

  assign curV[0] = inValid;
  assign curT[0] = inTag;
  assign curD[0] = inData;

  for (genvar s = 0; s < STAGES; s++) begin : g_tap
    assign curV[s+1] = regV[s];
    assign curT[s+1] = regT[s];
    assign curD[s+1] = regD[s];
  end

  // bitonic sorter: phase p merges runs of 2^p, step q compares at distance 2^(q-1)
  for (genvar p = 1; p <= LOGN; p++) begin : g_phase
    for (genvar q = p; q >= 1; q--) begin : g_step
      localparam int S = p * (p - 1) / 2 + (p - q);
      localparam int J = 1 << (q - 1);
      localparam int K = 1 << p;
      logic [NPORT-1:0]  vn;
      tag_t              tn [NPORT];
      logic [DATA_W-1:0] dn [NPORT];
      logic [LOGN:0]     keyA, keyB;
      logic              swap;
      int                l;

      always_comb begin
        vn   = curV[S];
        tn   = curT[S];
        dn   = curD[S];
        keyA = '0;
        keyB = '0;
        swap = 1'b0;
        l    = 0;
        for (int i = 0; i < NPORT; i++) begin
          if ((i & J) == 0) begin
            l    = i + J;
            keyA = {~curV[S][i], curT[S][i]};
            keyB = {~curV[S][l], curT[S][l]};
            swap = ((i & K) == 0) ? (keyA > keyB) : (keyA < keyB);
            if (swap) begin
              vn[i] = curV[S][l];  vn[l] = curV[S][i];
              tn[i] = curT[S][l];  tn[l] = curT[S][i];
              dn[i] = curD[S][l];  dn[l] = curD[S][i];
            end
          end
        end
      end

      assign nxV[S] = vn;
      assign nxT[S] = tn;
      assign nxD[S] = dn;
    end
  end

  // shuffle-exchange router, one tag bit per stage, MSB first
  for (genvar t = 0; t < ROUTE_STAGES; t++) begin : g_route
    localparam int S = SORT_STAGES + t;
    localparam int B = LOGN - 1 - t;
    logic [NPORT-1:0]  shV;
    tag_t              shT [NPORT];
    logic [DATA_W-1:0] shD [NPORT];
    logic [NPORT-1:0]  vn;
    tag_t              tn [NPORT];
    logic [DATA_W-1:0] dn [NPORT];
    int                r;

    always_comb begin
      shV = '0;
      shT = '{default: '0};
      shD = '{default: '0};
      vn  = '0;
      tn  = '{default: '0};
      dn  = '{default: '0};
      r   = 0;
      for (int i = 0; i < NPORT; i++) begin
        r      = ((i << 1) | (i >> (LOGN - 1))) & (NPORT - 1);
        shV[r] = curV[S][i];
        shT[r] = curT[S][i];
        shD[r] = curD[S][i];
      end
      for (int i = 0; i < NPORT / 2; i++) begin
        if (shV[2*i] && !shT[2*i][B]) begin
          vn[2*i] = 1'b1; tn[2*i] = shT[2*i]; dn[2*i] = shD[2*i];
        end else if (shV[2*i+1] && !shT[2*i+1][B]) begin
          vn[2*i] = 1'b1; tn[2*i] = shT[2*i+1]; dn[2*i] = shD[2*i+1];
        end
        if (shV[2*i] && shT[2*i][B]) begin
          vn[2*i+1] = 1'b1; tn[2*i+1] = shT[2*i]; dn[2*i+1] = shD[2*i];
        end else if (shV[2*i+1] && shT[2*i+1][B]) begin
          vn[2*i+1] = 1'b1; tn[2*i+1] = shT[2*i+1]; dn[2*i+1] = shD[2*i+1];
        end
      end
    end

    assign nxV[S] = vn;
    assign nxT[S] = tn;
    assign nxD[S] = dn;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < STAGES; s++) begin
      if (rst) begin
        regV[s] <= '0;
        regT[s] <= '{default: '0};
        regD[s] <= '{default: '0};
      end else if (stb.stageEn[s]) begin
        regV[s] <= nxV[s];
        regT[s] <= nxT[s];
        regD[s] <= nxD[s];
      end
    end
  end

  assign outValid = curV[STAGES];
  assign outData  = curD[STAGES];

  // R5: sorter output ordered by {not valid, tag}
  for (genvar i = 0; i < NPORT - 1; i++) begin : g_chk_sorted
    a_r5_sorted: assert property (@(posedge clk) disable iff (rst)
      {~curV[SORT_STAGES][i], curT[SORT_STAGES][i]} <=
      {~curV[SORT_STAGES][i+1], curT[SORT_STAGES][i+1]});
  end

  // R3: no sort stage gains or loses a cell
  for (genvar s = 0; s < SORT_STAGES; s++) begin : g_chk_count
    a_r3_count_kept: assert property (@(posedge clk) disable iff (rst)
      $countones(curV[s+1]) == $past($countones(curV[s])));
  end

  // R1: delivered cell sits on the port its tag names
  for (genvar p = 0; p < NPORT; p++) begin : g_chk_port
    a_r1_port_match: assert property (@(posedge clk) disable iff (rst)
      curV[STAGES][p] |-> (curT[STAGES][p] == tag_t'(p)));
  end

  // R7: a stage left disabled must not hold live cells
  for (genvar s = 0; s < STAGES; s++) begin : g_chk_gate
    a_r7_gate_safe: assert property (@(posedge clk) disable iff (rst)
      !stb.stageEn[s] |-> (curV[s+1] == '0));
  end
endmodule

// File: rtl/sort_route_fabric.sv
module sort_route_fabric import srf_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT-1:0]        inValid,
  input  logic [NPORT*LOGN-1:0]   inTags,
  input  logic [NPORT*DATA_W-1:0] inData,
  output logic [NPORT-1:0]        outValid,
  output logic [NPORT*DATA_W-1:0] outData,
  output logic                    dupErr
);
  tag_t              tagArr  [NPORT];
  logic [DATA_W-1:0] dataArr [NPORT];
  logic [DATA_W-1:0] outArr  [NPORT];
  strobes_t          stb;

  for (genvar i = 0; i < NPORT; i++) begin : g_lane
    assign tagArr[i]                     = inTags[i*LOGN +: LOGN];
    assign dataArr[i]                    = inData[i*DATA_W +: DATA_W];
    assign outData[i*DATA_W +: DATA_W]   = outArr[i];
  end

  srf_control u_ctl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inTag   (tagArr),
    .stb     (stb),
    .dupErr  (dupErr)
  );

  srf_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .inValid  (inValid),
    .inTag    (tagArr),
    .inData   (dataArr),
    .outValid (outValid),
    .outData  (outArr)
  );
endmodule

// File: tb/tb_sort_route_fabric.sv
`timescale 1ns/1ps
module tb_sort_route_fabric;
  localparam int NP  = 8;
  localparam int TW  = 3;
  localparam int DW  = 8;
  localparam int LAT = 9;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NP-1:0]    inValid = '0;
  logic [NP*TW-1:0] inTags  = '0;
  logic [NP*DW-1:0] inData  = '0;
  logic [NP-1:0]    outValid;
  logic [NP*DW-1:0] outData;
  logic             dupErr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [NP-1:0]    qV   [$];
  logic [NP*DW-1:0] qD   [$];
  bit               qDup [$];
  bit               qBusy[$];
  string            qLbl [$];

  always #2.5 clk = ~clk;

  sort_route_fabric #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inTags(inTags),
    .inData(inData), .outValid(outValid), .outData(outData), .dupErr(dupErr)
  );

  task automatic push_model(input logic [NP-1:0] v, input logic [NP*TW-1:0] t,
                            input logic [NP*DW-1:0] d, input string lbl);
    logic [NP-1:0]    ev = '0;
    logic [NP*DW-1:0] ed = '0;
    bit               dup = 0;
    for (int i = 0; i < NP; i++) begin
      if (v[i]) begin
        int tg = int'(t[i*TW +: TW]);
        if (ev[tg]) dup = 1;
        ev[tg] = 1'b1;
        ed[tg*DW +: DW] = d[i*DW +: DW];
      end
    end
    qV.push_back(ev); qD.push_back(ed); qDup.push_back(dup);
    qBusy.push_back(v != '0); qLbl.push_back(lbl);
  endtask

  task automatic compare_out();
    logic [NP-1:0]    ev  = qV.pop_front();
    logic [NP*DW-1:0] ed  = qD.pop_front();
    bit               dup = qDup.pop_front();
    bit               busy = qBusy.pop_front();
    string            lbl = qLbl.pop_front();
    total++;
    if (dupErr !== dup) begin
      bad++;
      $display("FAIL R6 (%s) dupErr act=%b exp=%b", lbl, dupErr, dup);
    end
    if (!dup) begin
      for (int p = 0; p < NP; p++) begin
        total++;
        if (outValid[p] !== ev[p]) begin
          bad++;
          $display("FAIL %s port %0d valid act=%b exp=%b",
                   (busy && !ev[p]) ? "R4" : lbl, p, outValid[p], ev[p]);
        end else if (ev[p]) begin
          total++;
          if (outData[p*DW +: DW] !== ed[p*DW +: DW]) begin
            bad++;
            $display("FAIL R1 (%s) port %0d data act=%h exp=%h",
                     lbl, p, outData[p*DW +: DW], ed[p*DW +: DW]);
          end
        end
      end
    end
  endtask

  task automatic step(input logic [NP-1:0] v, input logic [NP*TW-1:0] t,
                      input logic [NP*DW-1:0] d, input string lbl);
    @(negedge clk);
    compare_out();
    inValid = v; inTags = t; inData = d;
    push_model(v, t, d, lbl);
  endtask

  function automatic logic [NP*TW-1:0] rand_perm();
    int a [NP];
    logic [NP*TW-1:0] r = '0;
    for (int i = 0; i < NP; i++) a[i] = i;
    for (int i = NP - 1; i > 0; i--) begin
      int j = int'($urandom_range(i, 0));
      int x = a[i]; a[i] = a[j]; a[j] = x;
    end
    for (int i = 0; i < NP; i++) r[i*TW +: TW] = TW'(a[i]);
    return r;
  endfunction

  function automatic logic [NP*DW-1:0] rand_data();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NP*TW-1:0] t;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8: idle state right after reset
    total++;
    if (outValid !== '0) begin bad++; $display("FAIL R8 outValid act=%h exp=0", outValid); end
    total++;
    if (dupErr !== 1'b0) begin bad++; $display("FAIL R8 dupErr act=%b exp=0", dupErr); end
    for (int i = 0; i < LAT; i++) push_model('0, '0, '0, "R8");

    // R2: a lone cell, then idle cycles that must stay empty until edge 9
    t = '0; t[3*TW +: TW] = 3'd5;
    step(8'b0000_1000, t, rand_data(), "R2");
    for (int i = 0; i < 12; i++) step('0, '0, '0, "R2");

    // R1: identity and reversed full loads
    for (int i = 0; i < NP; i++) t[i*TW +: TW] = TW'(i);
    step('1, t, rand_data(), "R1");
    for (int i = 0; i < NP; i++) t[i*TW +: TW] = TW'(NP - 1 - i);
    step('1, t, rand_data(), "R1");

    // R7: back-to-back full loads
    for (int i = 0; i < 60; i++) step('1, rand_perm(), rand_data(), "R7");
    // R3: random full permutations with gaps
    for (int i = 0; i < 150; i++) begin
      step('1, rand_perm(), rand_data(), "R3");
      if (i % 7 == 0) step('0, rand_perm(), rand_data(), "R3");
    end
    // R5: partial loads, idle lanes anywhere
    for (int i = 0; i < 200; i++) step(NP'($urandom), rand_perm(), rand_data(), "R5");
    // R5: single cell on the top lane targeting port 0
    t = '0; t[7*TW +: TW] = 3'd0;
    step(8'b1000_0000, t, rand_data(), "R5");

    // R6: repeated tags flagged, neighbours clean
    for (int i = 0; i < 20; i++) begin
      t = rand_perm();
      t[2*TW +: TW] = t[6*TW +: TW];
      step(8'b0100_0100 | NP'($urandom), t, rand_data(), "R6");
      step('1, rand_perm(), rand_data(), "R6");
      step('0, '0, '0, "R6");
    end

    for (int i = 0; i < LAT + 2; i++) step('0, '0, '0, "R4");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule